// File: doc/BRIEF.md
# Block-Matching SAD Engine

This engine scores one candidate block against a current block by the sum of absolute differences over a 16x16 pixel grid. The current block is written one row per cycle under a write enable and stays resident until rows are written again. Reference pixels arrive one column per cycle. Each column enters at the right edge of a 16x16 candidate window while the leftmost column drops out, so a sweep of columns walks the candidate across a search strip.

All 256 pixel differences are formed in one registered stage. They are then reduced by a pipelined binary adder tree of eight registered levels, each level one bit wider than the one before. The 16-bit result cannot wrap. Once sixteen columns have entered, every further column shift yields one result, flagged by a valid bit that travels with the data. This gives one score per cycle during a continuous sweep.

Top module: `sad256_engine`

## Requirements
- R1: In both the row word and the column word, pixel k occupies bits [8k+7:8k]. In a row word, pixel k is column k. In a column word, pixel k is row k.
- R2: Each cycle with `cur_we` high writes `cur_row` into the next current-block row. After reset the first write goes to row 0, and the row after row 15 is row 0 again. Rows are unchanged in cycles with `cur_we` low.
- R3: `sad_sum` equals the sum over all 256 positions of |current − candidate|, with each difference a non-negative magnitude whichever pixel is larger. The extreme 256 × 255 = 65280 is reported without wrap.
- R4: Each cycle with `col_shift` high moves the candidate window one column toward column 0, discarding column 0 and placing `col_data` in column 15.
- R5: A result is produced for a shift only when at least 16 columns have entered since reset, counting that shift. Exactly one result is produced per such shift, and the first 15 shifts produce none.
- R6: A shift sampled at rising edge k delivers its result, with `sad_vld` high, after rising edge k+9. Consecutive shifts give results on consecutive cycles.
- R7: While `rst` is high and directly after it, `sad_vld` is low. Reset clears the column count and the row write position, and it drops results still in flight.
- R8: A row written in the same cycle as a column shift is part of the block used for that shift's result.
- R9: A cycle with `col_shift` low produces no result and leaves the candidate window as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cur_we | input | 1 | Write `cur_row` into the next current-block row |
| cur_row | input | 128 | Sixteen 8-bit pixels of one current-block row |
| col_shift | input | 1 | Shift `col_data` into the candidate window |
| col_data | input | 128 | Sixteen 8-bit pixels of one reference column |
| sad_vld | output | 1 | `sad_sum` holds a fresh result |
| sad_sum | output | 16 | Sum of absolute differences |

## Verification
The delicate overlap is a current-block row write landing in the same cycle as a column shift. The expected result must then reflect the freshly written row together with the freshly shifted column. The bench drives long stretches with both enables high at once and keeps a reference model that applies the row write and the column shift before scoring. A scoreboard compares every result against that model, checks the arrival cycle, and treats any missing or unexpected result as a failure.

// File: rtl/sad_pkg.sv
package sad_pkg;
    parameter int PIX_W  = 8;
    parameter int BLK_N  = 16;
    parameter int NUM_PX = BLK_N * BLK_N;
    parameter int LEVELS = $clog2(NUM_PX);
    parameter int SAD_W  = PIX_W + LEVELS;
    parameter int WORD_W = PIX_W * BLK_N;
    parameter int CNT_W  = $clog2(BLK_N + 1);
    parameter int PIPE_LAT = LEVELS + 2;

    typedef logic [PIX_W-1:0]  pix_t;
    typedef pix_t [BLK_N-1:0]  line_t;
    typedef line_t [BLK_N-1:0] block_t;

    typedef struct packed {
        logic             vld;
        logic [SAD_W-1:0] sum;
    } sad_res_t;

    function automatic pix_t abs_gap(input pix_t a, input pix_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction
endpackage

// File: rtl/sad_cur_store.sv
module sad_cur_store
    import sad_pkg::*;
#(
    parameter int N = BLK_N
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [WORD_W-1:0]     row_word,
    output block_t                blk
);
    localparam int PTR_W = $clog2(N);

    logic [PTR_W-1:0] wr_ptr;
    block_t           blk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
        end else if (we) begin
            wr_ptr <= (wr_ptr == PTR_W'(N - 1)) ? '0 : wr_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            blk_q[wr_ptr] <= line_t'(row_word);
        end
    end

    assign blk = blk_q;
endmodule

// File: rtl/sad_ref_window.sv
module sad_ref_window
    import sad_pkg::*;
#(
    parameter int N = BLK_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift,
    input  logic [WORD_W-1:0] col_word,
    output block_t            win,
    output logic              win_vld
);
    logic [CNT_W-1:0] fill_q;
    block_t           win_q;
    line_t            col_px;

    assign col_px = line_t'(col_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q  <= '0;
            win_vld <= 1'b0;
        end else begin
            win_vld <= shift && (fill_q >= CNT_W'(N - 1));
            if (shift && fill_q != CNT_W'(N)) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (shift) begin
            for (int r = 0; r < N; r++) begin
                for (int c = 0; c < N - 1; c++) begin
                    win_q[r][c] <= win_q[r][c+1];
                end
                win_q[r][N-1] <= col_px[r];
            end
        end
    end

    assign win = win_q;
endmodule

// File: rtl/sad_absdiff_array.sv
module sad_absdiff_array
    import sad_pkg::*;
#(
    parameter int N = BLK_N
) (
    input  logic                   clk,
    input  logic                   rst,
    input  block_t                 cur,
    input  block_t                 cand,
    input  logic                   in_vld,
    output logic [N*N*PIX_W-1:0]   ad_bus,
    output logic                   ad_vld
);
    always_ff @(posedge clk) begin
        if (rst) ad_vld <= 1'b0;
        else     ad_vld <= in_vld;
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                ad_bus[(r*N + c)*PIX_W +: PIX_W] <= abs_gap(cur[r][c], cand[r][c]);
            end
        end
    end
endmodule

// File: rtl/sad_adder_tree.sv
module sad_adder_tree
    import sad_pkg::*;
#(
    parameter int NUM = NUM_PX,
    parameter int IN_W = PIX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM*IN_W-1:0] leaf_bus,
    input  logic                leaf_vld,
    output sad_res_t            res
);
    localparam int DEPTH = $clog2(NUM);

    for (genvar l = 0; l <= DEPTH; l++) begin : lv
        localparam int W   = IN_W + l;
        localparam int CNT = NUM >> l;
        logic [W-1:0] node [CNT];
        logic         vld;

        if (l == 0) begin : g_leaf
            always_comb begin
                for (int i = 0; i < CNT; i++) begin
                    node[i] = leaf_bus[i*IN_W +: IN_W];
                end
            end
            assign vld = leaf_vld;
        end else begin : g_sum
            always_ff @(posedge clk) begin
                if (rst) vld <= 1'b0;
                else     vld <= lv[l-1].vld;
            end
            always_ff @(posedge clk) begin
                for (int i = 0; i < CNT; i++) begin
                    node[i] <= {1'b0, lv[l-1].node[2*i]} + {1'b0, lv[l-1].node[2*i+1]};
                end
            end
        end
    end

    assign res.vld = lv[DEPTH].vld;
    assign res.sum = SAD_W'(lv[DEPTH].node[0]);
endmodule

// File: rtl/sad256_engine.sv
module sad256_engine
    import sad_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cur_we,
    input  logic [WORD_W-1:0]  cur_row,
    input  logic               col_shift,
    input  logic [WORD_W-1:0]  col_data,
    output logic               sad_vld,
    output logic [SAD_W-1:0]   sad_sum
);
    block_t                    cur_q;
    block_t                    win_q;
    logic                      win_vld;
    logic [NUM_PX*PIX_W-1:0]   ad_bus;
    logic                      ad_vld;
    sad_res_t                  res;

    sad_cur_store #(.N(BLK_N)) u_cur (
        .clk(clk), .rst(rst), .we(cur_we), .row_word(cur_row), .blk(cur_q)
    );

    sad_ref_window #(.N(BLK_N)) u_win (
        .clk(clk), .rst(rst), .shift(col_shift), .col_word(col_data),
        .win(win_q), .win_vld(win_vld)
    );

    sad_absdiff_array #(.N(BLK_N)) u_ad (
        .clk(clk), .rst(rst), .cur(cur_q), .cand(win_q), .in_vld(win_vld),
        .ad_bus(ad_bus), .ad_vld(ad_vld)
    );

    sad_adder_tree #(.NUM(NUM_PX), .IN_W(PIX_W)) u_tree (
        .clk(clk), .rst(rst), .leaf_bus(ad_bus), .leaf_vld(ad_vld), .res(res)
    );

    assign sad_vld = res.vld;
    assign sad_sum = res.sum;
endmodule

// File: rtl/sad256_engine_chk.sv
module sad256_engine_chk
    import sad_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cur_we,
    input logic              col_shift,
    input logic [WORD_W-1:0] col_data,
    input logic              sad_vld,
    input logic [SAD_W-1:0]  sad_sum,
    input block_t            win,
    input block_t            cur_blk
);
    logic [CNT_W-1:0]    seen;
    logic [PIPE_LAT-1:0] due;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= '0;
            due  <= '0;
        end else begin
            due <= {due[PIPE_LAT-2:0], col_shift && (seen >= CNT_W'(BLK_N - 1))};
            if (col_shift && seen != CNT_W'(BLK_N)) seen <= seen + 1'b1;
        end
    end

    // R5 and R6: result flag matches shift history and latency
    p_valid_timing_r5: assert property (@(posedge clk) disable iff (rst)
        sad_vld == due[PIPE_LAT-1]);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        sad_vld |-> (sad_sum <= SAD_W'(NUM_PX * 255)));

    p_quiet_after_reset_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !sad_vld);

    p_window_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !col_shift |=> $stable(win));

    p_rows_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !cur_we |=> $stable(cur_blk));

    for (genvar r = 0; r < BLK_N; r++) begin : g_row
        p_column_entry_r4: assert property (@(posedge clk) disable iff (rst)
            col_shift |=> win[r][BLK_N-1] == $past(col_data[r*PIX_W +: PIX_W]));
    end
endmodule

bind sad256_engine sad256_engine_chk u_chk (
    .clk(clk), .rst(rst), .cur_we(cur_we), .col_shift(col_shift),
    .col_data(col_data), .sad_vld(sad_vld), .sad_sum(sad_sum),
    .win(win_q), .cur_blk(cur_q)
);

// File: tb/sad256_engine_test.sv
module sad256_engine_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cur_we = 1'b0;
    logic [127:0] cur_row = '0;
    logic         col_shift = 1'b0;
    logic [127:0] col_data = '0;
    logic         sad_vld;
    logic [15:0]  sad_sum;

    always #2 clk = ~clk;

    sad256_engine uut (
        .clk(clk), .rst(rst), .cur_we(cur_we), .cur_row(cur_row),
        .col_shift(col_shift), .col_data(col_data),
        .sad_vld(sad_vld), .sad_sum(sad_sum)
    );

    typedef struct {
        int    sum;
        int    cyc;
        string tag;
    } exp_t;

    exp_t  sb[$];
    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    int    last_sum = -1;
    bit    done = 1'b0;
    int    cur_m [16][16];
    int    win_m [16][16];
    int    ptr_m = 0;
    int    fill_m = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [127:0] pat(input int s, input int k0, input int k1);
        logic [127:0] w;
        for (int k = 0; k < 16; k++) w[k*8 +: 8] = 8'((s * k0 + k * k1 + (s ^ k)) & 255);
        return w;
    endfunction

    function automatic int model_sad();
        int acc = 0;
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++)
                acc += (cur_m[r][c] > win_m[r][c]) ? cur_m[r][c] - win_m[r][c]
                                                   : win_m[r][c] - cur_m[r][c];
        return acc;
    endfunction

    // driver: one cycle of stimulus, model update, expected push
    task automatic step(input bit ld, input logic [127:0] row,
                        input bit sh, input logic [127:0] col, input string tag);
        exp_t e;
        @(negedge clk);
        cur_we = ld; cur_row = row; col_shift = sh; col_data = col;
        if (ld) begin
            for (int c = 0; c < 16; c++) cur_m[ptr_m][c] = int'(row[c*8 +: 8]);
            ptr_m = (ptr_m + 1) % 16;
        end
        if (sh) begin
            for (int r = 0; r < 16; r++) begin
                for (int c = 0; c < 15; c++) win_m[r][c] = win_m[r][c+1];
                win_m[r][15] = int'(col[r*8 +: 8]);
            end
            if (fill_m < 16) fill_m++;
            if (fill_m >= 16) begin
                e.sum = model_sad(); e.cyc = cyc + 10; e.tag = tag;
                sb.push_back(e);
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, '0, "R9");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cur_we = 1'b0; col_shift = 1'b0;
        repeat (2) @(negedge clk);
        if (sad_vld !== 1'b0) begin
            failures++;
            $display("FAIL R7 valid during reset actual=%0b expected=0", sad_vld);
        end
        checks++;
        rst = 1'b0;
        sb.delete();
        ptr_m = 0; fill_m = 0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && sad_vld) begin
            checks++;
            if (sb.size() == 0) begin
                failures++;
                $display("FAIL R5 unexpected result actual=%0d expected=none", sad_sum);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (int'(sad_sum) != e.sum || cyc != e.cyc) begin
                    failures++;
                    $display("FAIL %s/R6 sum actual=%0d expected=%0d cycle actual=%0d expected=%0d",
                             e.tag, sad_sum, e.sum, cyc, e.cyc);
                end
            end
            last_sum = int'(sad_sum);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++) begin cur_m[r][c] = 0; win_m[r][c] = 0; end
        repeat (3) @(negedge clk);
        // R7: reset state
        do_reset();
        @(negedge clk);
        checks++;
        if (sad_vld !== 1'b0) begin
            failures++;
            $display("FAIL R7 valid after reset actual=%0b expected=0", sad_vld);
        end
        // R2/R1: load current block, asymmetric per-pixel pattern
        for (int i = 0; i < 16; i++) step(1'b1, pat(i, 17, 5), 1'b0, '0, "R2");
        // R5: first 15 shifts give nothing; R1,R4: later shifts scored
        for (int i = 0; i < 15; i++) step(1'b0, '0, 1'b1, pat(i + 40, 7, 13), "R5");
        for (int i = 0; i < 12; i++) step(1'b0, '0, 1'b1, pat(i + 90, 29, 3), "R1,R4");
        // R9: pauses keep the window
        idle(6);
        for (int i = 0; i < 3; i++) begin
            step(1'b0, '0, 1'b1, pat(i + 7, 11, 19), "R9");
            idle(2);
        end
        // R8: row writes coinciding with shifts
        for (int i = 0; i < 24; i++) step(1'b1, pat(i + 200, 3, 23), 1'b1, pat(i + 300, 31, 9), "R8");
        // R2: wrap of write position without shifts, then score
        for (int i = 0; i < 20; i++) step(1'b1, pat(i + 500, 13, 7), 1'b0, '0, "R2");
        for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1, pat(i + 600, 5, 37), "R2");
        // R3: extreme magnitude, both orderings
        for (int i = 0; i < 16; i++) step(1'b1, {16{8'hFF}}, 1'b1, '0, "R3");
        idle(12);
        checks++;
        if (last_sum != 65280) begin
            failures++;
            $display("FAIL R3 max sum actual=%0d expected=65280", last_sum);
        end
        for (int i = 0; i < 16; i++) step(1'b1, '0, 1'b1, {16{8'hFF}}, "R3");
        idle(12);
        checks++;
        if (last_sum != 65280) begin
            failures++;
            $display("FAIL R3 reversed max actual=%0d expected=65280", last_sum);
        end
        // R7: reset with results in flight, then refill
        for (int i = 0; i < 5; i++) step(1'b0, '0, 1'b1, pat(i + 700, 9, 9), "R7");
        do_reset();
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++) cur_m[r][c] = cur_m[r][c];
        for (int i = 0; i < 16; i++) step(1'b1, pat(i + 800, 21, 15), 1'b0, '0, "R7");
        for (int i = 0; i < 15; i++) step(1'b0, '0, 1'b1, pat(i + 900, 27, 1), "R5");
        for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, pat(i + 950, 2, 41), "R5");
        idle(14);
        checks++;
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL R5 missing results actual=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule